// File: doc/BRIEF.md
# Banked CPU Register File with Mode-Selected Stack Pointer

This block is the general-purpose register file of a 16-bit CPU core. It holds eight architectural registers. Each one can be read or written as a whole 16-bit word or as either of its two bytes. Registers 0 through 3 exist in four copies, called banks. A 2-bit bank input picks which copy an access reaches. Registers 4 through 6 are a single set that every bank sees. Register 7 has no storage of its own. It is a window onto one of two hidden stack pointers: the user pointer when the system-mode input is low, and the system pointer when it is high. Both pointers start at 0x0100.

The core reaches the file through one combinational read port and one write port that updates on the clock edge. Both ports use a byte index. In word mode, bit 0 of the index is ignored. Two stack helper inputs adjust the active stack pointer for the core's stack unit:
- A push lowers the pointer by two before the store and presents the lowered value as the stack address.
- A pop presents the current pointer as the address and then raises it by two.

The memory traffic of the stack lies outside this block. The registers belong to no memory address space.

Top module: `banked_regfile`

## Requirements
- R1: After reset every stored register (R0..R3 of all banks, R4..R6) reads 0x0000, and R7 reads 0x0100 in both modes.
- R2: A write to R0..R3 changes only the copy in the bank given by the bank input; the same register in the other banks keeps its value.
- R3: R4..R6 are one set shared by all banks; a write through any bank is seen through every bank.
- R4: R7 reads and writes the user stack pointer when the mode input is 0 and the system stack pointer when it is 1; the other pointer is untouched by the access.
- R5: In byte mode, index 2n selects the low byte (bits 7:0) of register n and index 2n+1 its high byte (bits 15:8); a byte read returns the byte on bits 7:0 with bits 15:8 zero.
- R6: A byte write takes its data from bits 7:0 of the write data and leaves the other byte of the register unchanged.
- R7: In word mode bit 0 of the index is ignored, so index 2n+1 accesses the same register as 2n.
- R8: During a push cycle the stack address output equals the active pointer minus 2, and after the edge the active pointer holds that value; the first push after reset gives 0x00FE.
- R9: During a pop cycle the stack address output equals the active pointer, and after the edge the pointer is 2 higher.
- R10: Push and pop asserted together leave both pointers unchanged, and the stack address equals the active pointer.
- R11: A lone push or pop overrides a write to R7 in the same cycle.
- R12: A read of the register being written in the same cycle returns the old value; the new value appears after the edge.
- R13: The inactive stack pointer is unchanged by push, pop or R7 writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| bank_sel | input | 2 | Bank used for R0..R3 |
| sys_mode | input | 1 | 0 selects the user stack pointer for R7, 1 the system one |
| rd_word | input | 1 | 1 = word read, 0 = byte read |
| rd_sel | input | 4 | Read byte index (word mode ignores bit 0) |
| rd_data | output | 16 | Read result; byte reads are zero-extended |
| wr_en | input | 1 | Write enable |
| wr_word | input | 1 | 1 = word write, 0 = byte write |
| wr_sel | input | 4 | Write byte index (word mode ignores bit 0) |
| wr_data | input | 16 | Write data; byte writes use bits 7:0 |
| push | input | 1 | Pre-decrement the active stack pointer by 2 |
| pop | input | 1 | Post-increment the active stack pointer by 2 |
| stack_addr | output | 16 | Address of the current stack access |

## Verification
The stack-pointer properties compare each pointer with its own value one cycle earlier. They therefore assume that the mode input holds still for the whole cycle in which a push or pop is sampled. The stimulus changes the mode only on the falling edge, between operations. The byte-read property assumes nothing about the index, so the sweeps visit every byte index in every bank. The pointer values stay far from wrap-around: at most a few dozen steps away from 0x0100 or from the values written into R7.

// File: rtl/banked_regfile_pkg.sv
package banked_regfile_pkg;

   typedef enum logic [1:0] {
      STK_HOLD = 2'd0,
      STK_DOWN = 2'd1,
      STK_UP   = 2'd2
   } stk_op_e;

   // lane enables for a two-lane word: word access hits both lanes,
   // byte access hits the lane named by the index's lowest bit
   function automatic logic [1:0] lane_enables(input logic word, input logic hi);
      if (word) return 2'b11;
      return hi ? 2'b10 : 2'b01;
   endfunction

   function automatic stk_op_e decode_stack(input logic dn, input logic up);
      if (dn && !up) return STK_DOWN;
      if (up && !dn) return STK_UP;
      return STK_HOLD;
   endfunction

endpackage

// File: rtl/rf_addr_map.sv
module rf_addr_map #(
   parameter int NUM_BANKS   = 4,
   parameter int BANKED_REGS = 4,
   parameter int NUM_REGS    = 8,
   localparam int BANK_W     = $clog2(NUM_BANKS),
   localparam int REG_W      = $clog2(NUM_REGS),
   localparam int NUM_SLOTS  = NUM_BANKS * BANKED_REGS + (NUM_REGS - BANKED_REGS - 1),
   localparam int SLOT_W     = $clog2(NUM_SLOTS)
) (
   input  logic [BANK_W-1:0] bank,
   input  logic [REG_W-1:0]  reg_idx,
   output logic [SLOT_W-1:0] slot,
   output logic              is_sp
);
   localparam int GLOBAL_BASE = NUM_BANKS * BANKED_REGS;

   always_comb begin
      is_sp = (int'(reg_idx) == NUM_REGS - 1);
      if (int'(reg_idx) < BANKED_REGS)
         slot = SLOT_W'(int'(bank) * BANKED_REGS + int'(reg_idx));
      else if (!is_sp)
         slot = SLOT_W'(GLOBAL_BASE + int'(reg_idx) - BANKED_REGS);
      else
         slot = '0;
   end
endmodule

// File: rtl/rf_storage.sv
module rf_storage #(
   parameter int DATA_W    = 16,
   parameter int NUM_SLOTS = 19,
   localparam int SLOT_W   = $clog2(NUM_SLOTS),
   localparam int LANE_W   = DATA_W / 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [SLOT_W-1:0] wr_slot,
   input  logic [1:0]        wr_be,
   input  logic [DATA_W-1:0] wr_lanes,
   input  logic [SLOT_W-1:0] rd_slot,
   output logic [DATA_W-1:0] rd_value
);
   logic [DATA_W-1:0] mem [NUM_SLOTS];

   for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
      for (genvar l = 0; l < 2; l++) begin : g_lane
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               mem[s][l*LANE_W +: LANE_W] <= '0;
            else if (wr_en && int'(wr_slot) == s && wr_be[l])
               mem[s][l*LANE_W +: LANE_W] <= wr_lanes[l*LANE_W +: LANE_W];
         end
      end
   end

   always_comb begin
      if (int'(rd_slot) < NUM_SLOTS)
         rd_value = mem[rd_slot];
      else
         rd_value = '0;
   end
endmodule

// File: rtl/rf_sp_unit.sv
module rf_sp_unit
   import banked_regfile_pkg::*;
#(
   parameter int              DATA_W   = 16,
   parameter logic [DATA_W-1:0] SP_RESET = 16'h0100,
   parameter int              SP_STEP  = 2,
   localparam int             LANE_W   = DATA_W / 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sys_mode,
   input  logic              push,
   input  logic              pop,
   input  logic              wr_en,
   input  logic [1:0]        wr_be,
   input  logic [DATA_W-1:0] wr_lanes,
   output logic [DATA_W-1:0] usp,
   output logic [DATA_W-1:0] ssp,
   output logic [DATA_W-1:0] active_sp,
   output logic [DATA_W-1:0] stack_addr
);
   localparam logic [DATA_W-1:0] STEP = DATA_W'(SP_STEP);

   logic [DATA_W-1:0] sp_q [2];
   logic [DATA_W-1:0] merged;
   logic [DATA_W-1:0] next_sp;
   stk_op_e           op;

   assign active_sp = sp_q[sys_mode];
   assign usp       = sp_q[0];
   assign ssp       = sp_q[1];
   assign op        = decode_stack(push, pop);

   always_comb begin
      for (int l = 0; l < 2; l++)
         merged[l*LANE_W +: LANE_W] = wr_be[l] ? wr_lanes[l*LANE_W +: LANE_W]
                                               : active_sp[l*LANE_W +: LANE_W];
      unique case (op)
         STK_DOWN: next_sp = active_sp - STEP;
         STK_UP:   next_sp = active_sp + STEP;
         default:  next_sp = wr_en ? merged : active_sp;
      endcase
      stack_addr = (op == STK_DOWN) ? active_sp - STEP : active_sp;
   end

   for (genvar m = 0; m < 2; m++) begin : g_sp
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            sp_q[m] <= SP_RESET;
         else if (int'(sys_mode) == m)
            sp_q[m] <= next_sp;
      end
   end
endmodule

// File: rtl/banked_regfile.sv
module banked_regfile
   import banked_regfile_pkg::*;
#(
   parameter int              DATA_W      = 16,
   parameter int              NUM_BANKS   = 4,
   parameter int              BANKED_REGS = 4,
   parameter int              NUM_REGS    = 8,
   parameter logic [DATA_W-1:0] SP_RESET  = 16'h0100,
   parameter int              SP_STEP     = 2,
   localparam int             BANK_W      = $clog2(NUM_BANKS),
   localparam int             REG_W       = $clog2(NUM_REGS),
   localparam int             SEL_W       = REG_W + 1,
   localparam int             LANE_W      = DATA_W / 2,
   localparam int             NUM_SLOTS   = NUM_BANKS * BANKED_REGS + (NUM_REGS - BANKED_REGS - 1),
   localparam int             SLOT_W      = $clog2(NUM_SLOTS)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [BANK_W-1:0] bank_sel,
   input  logic              sys_mode,
   input  logic              rd_word,
   input  logic [SEL_W-1:0]  rd_sel,
   output logic [DATA_W-1:0] rd_data,
   input  logic              wr_en,
   input  logic              wr_word,
   input  logic [SEL_W-1:0]  wr_sel,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              push,
   input  logic              pop,
   output logic [DATA_W-1:0] stack_addr
);
   // elaboration-time parameter checks
   if (DATA_W % 2 != 0) begin : g_bad_width
      $error("DATA_W must split into two equal byte lanes");
   end
   if (BANKED_REGS >= NUM_REGS) begin : g_bad_regs
      $error("BANKED_REGS must leave room for shared registers and the stack alias");
   end
   if ((1 << BANK_W) != NUM_BANKS || (1 << REG_W) != NUM_REGS) begin : g_bad_pow2
      $error("NUM_BANKS and NUM_REGS must be powers of two");
   end
   if (SP_STEP <= 0) begin : g_bad_step
      $error("SP_STEP must be positive");
   end

   logic [SLOT_W-1:0] rd_slot, wr_slot;
   logic              rd_is_sp, wr_is_sp;
   logic [1:0]        wr_be;
   logic [DATA_W-1:0] wr_lanes;
   logic [DATA_W-1:0] store_value, reg_value;
   logic [DATA_W-1:0] usp, ssp, active_sp;

   rf_addr_map #(.NUM_BANKS(NUM_BANKS), .BANKED_REGS(BANKED_REGS), .NUM_REGS(NUM_REGS))
   u_rd_map (.bank(bank_sel), .reg_idx(rd_sel[SEL_W-1:1]), .slot(rd_slot), .is_sp(rd_is_sp));

   rf_addr_map #(.NUM_BANKS(NUM_BANKS), .BANKED_REGS(BANKED_REGS), .NUM_REGS(NUM_REGS))
   u_wr_map (.bank(bank_sel), .reg_idx(wr_sel[SEL_W-1:1]), .slot(wr_slot), .is_sp(wr_is_sp));

   assign wr_be    = lane_enables(wr_word, wr_sel[0]);
   assign wr_lanes = wr_word ? wr_data : {wr_data[LANE_W-1:0], wr_data[LANE_W-1:0]};

   rf_storage #(.DATA_W(DATA_W), .NUM_SLOTS(NUM_SLOTS)) u_store (
      .clk(clk), .rst_n(rst_n),
      .wr_en(wr_en && !wr_is_sp), .wr_slot(wr_slot), .wr_be(wr_be), .wr_lanes(wr_lanes),
      .rd_slot(rd_slot), .rd_value(store_value)
   );

   rf_sp_unit #(.DATA_W(DATA_W), .SP_RESET(SP_RESET), .SP_STEP(SP_STEP)) u_sp (
      .clk(clk), .rst_n(rst_n), .sys_mode(sys_mode), .push(push), .pop(pop),
      .wr_en(wr_en && wr_is_sp), .wr_be(wr_be), .wr_lanes(wr_lanes),
      .usp(usp), .ssp(ssp), .active_sp(active_sp), .stack_addr(stack_addr)
   );

   assign reg_value = rd_is_sp ? active_sp : store_value;

   always_comb begin
      if (rd_word)
         rd_data = reg_value;
      else if (rd_sel[0])
         rd_data = {{LANE_W{1'b0}}, reg_value[DATA_W-1:LANE_W]};
      else
         rd_data = {{LANE_W{1'b0}}, reg_value[LANE_W-1:0]};
   end
endmodule

// File: rtl/rf_checker.sv
module rf_checker #(
   parameter int DATA_W  = 16,
   parameter int SP_STEP = 2,
   localparam int LANE_W = DATA_W / 2
) (
   input logic              clk,
   input logic              rst_n,
   input logic              sys_mode,
   input logic              push,
   input logic              pop,
   input logic              rd_word,
   input logic [DATA_W-1:0] rd_data,
   input logic [DATA_W-1:0] stack_addr,
   input logic [DATA_W-1:0] usp,
   input logic [DATA_W-1:0] ssp
);
   localparam logic [DATA_W-1:0] STEP = DATA_W'(SP_STEP);

   // R8: push on the user pointer lowers it by the step
   a_r8_user_push_dec: assert property (@(posedge clk) disable iff (!rst_n)
      (push && !pop && !sys_mode) |=> usp == $past(usp) - STEP);

   // R8: stack address during a push is the lowered pointer
   a_r8_push_addr: assert property (@(posedge clk) disable iff (!rst_n)
      (push && !pop) |-> stack_addr == (sys_mode ? ssp : usp) - STEP);

   // R9: pop on the system pointer raises it by the step
   a_r9_sys_pop_inc: assert property (@(posedge clk) disable iff (!rst_n)
      (pop && !push && sys_mode) |=> ssp == $past(ssp) + STEP);

   // R10: simultaneous push and pop keep the pointer
   a_r10_both_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (push && pop && !sys_mode) |=> usp == $past(usp));

   // R13: inactive pointer never moves
   a_r13_ssp_idle: assert property (@(posedge clk) disable iff (!rst_n)
      !sys_mode |=> ssp == $past(ssp));
   a_r13_usp_idle: assert property (@(posedge clk) disable iff (!rst_n)
      sys_mode |=> usp == $past(usp));

   // R5: byte reads are zero-extended
   a_r5_byte_zero_ext: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_word |-> rd_data[DATA_W-1:LANE_W] == '0);
endmodule

bind banked_regfile rf_checker #(.DATA_W(DATA_W), .SP_STEP(SP_STEP)) u_rf_checker (
   .clk(clk), .rst_n(rst_n), .sys_mode(sys_mode), .push(push), .pop(pop),
   .rd_word(rd_word), .rd_data(rd_data), .stack_addr(stack_addr),
   .usp(usp), .ssp(ssp)
);

// File: tb/test_banked_regfile.sv
module test_banked_regfile;
   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [1:0]  bank_sel = '0;
   logic        sys_mode = 1'b0;
   logic        rd_word = 1'b1;
   logic [3:0]  rd_sel = '0;
   logic [15:0] rd_data;
   logic        wr_en = 1'b0;
   logic        wr_word = 1'b1;
   logic [3:0]  wr_sel = '0;
   logic [15:0] wr_data = '0;
   logic        push = 1'b0;
   logic        pop = 1'b0;
   logic [15:0] stack_addr;

   int n_cmp = 0;
   int n_bad = 0;
   bit done = 0;

   // reference model
   logic [15:0] m_bank [4][4];
   logic [15:0] m_glob [3];
   logic [15:0] m_sp   [2];

   always #(CLK_PERIOD/2) clk = ~clk;

   banked_regfile i_banked_regfile (
      .clk(clk), .rst_n(rst_n), .bank_sel(bank_sel), .sys_mode(sys_mode),
      .rd_word(rd_word), .rd_sel(rd_sel), .rd_data(rd_data),
      .wr_en(wr_en), .wr_word(wr_word), .wr_sel(wr_sel), .wr_data(wr_data),
      .push(push), .pop(pop), .stack_addr(stack_addr)
   );

   task automatic chk(input logic [15:0] act, input logic [15:0] exp, input string tag);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: got %h expected %h", tag, act, exp);
      end
   endtask

   function automatic logic [15:0] m_word(input int b, input int r, input bit mode);
      if (r < 4) return m_bank[b][r];
      if (r < 7) return m_glob[r-4];
      return m_sp[mode];
   endfunction

   task automatic m_store(input int b, input int r, input bit mode, input logic [15:0] v);
      if (r < 4) m_bank[b][r] = v;
      else if (r < 7) m_glob[r-4] = v;
      else m_sp[mode] = v;
   endtask

   task automatic model_reset();
      for (int b = 0; b < 4; b++)
         for (int r = 0; r < 4; r++) m_bank[b][r] = '0;
      for (int g = 0; g < 3; g++) m_glob[g] = '0;
      m_sp[0] = 16'h0100;
      m_sp[1] = 16'h0100;
   endtask

   task automatic do_reset();
      rst_n = 1'b0;
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
      model_reset();
   endtask

   // called at a falling edge; returns at the next falling edge
   task automatic do_write(input int b, input bit mode, input bit word, input int sel,
                           input logic [15:0] d);
      logic [15:0] v;
      int r;
      bank_sel = 2'(b); sys_mode = mode;
      wr_en = 1'b1; wr_word = word; wr_sel = 4'(sel); wr_data = d;
      @(posedge clk);
      r = sel >> 1;
      v = m_word(b, r, mode);
      if (word) v = d;
      else if (sel[0]) v[15:8] = d[7:0];
      else v[7:0] = d[7:0];
      m_store(b, r, mode, v);
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic rd_chk(input int b, input bit mode, input bit word, input int sel,
                         input string tag);
      logic [15:0] v, e;
      bank_sel = 2'(b); sys_mode = mode; rd_word = word; rd_sel = 4'(sel);
      #1;
      v = m_word(b, sel >> 1, mode);
      if (word) e = v;
      else e = sel[0] ? {8'h00, v[15:8]} : {8'h00, v[7:0]};
      chk(rd_data, e, tag);
   endtask

   task automatic stack_op(input bit mode, input bit p_dn, input bit p_up, input string tag);
      logic [15:0] cur, e_addr;
      sys_mode = mode; push = p_dn; pop = p_up;
      #1;
      cur = m_sp[mode];
      e_addr = (p_dn && !p_up) ? cur - 16'd2 : cur;
      chk(stack_addr, e_addr, tag);
      @(posedge clk);
      if (p_dn && !p_up) m_sp[mode] = cur - 16'd2;
      else if (p_up && !p_dn) m_sp[mode] = cur + 16'd2;
      @(negedge clk);
      push = 1'b0; pop = 1'b0;
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1;
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   endtask

   initial begin
      #(CLK_PERIOD * 50000);
      n_cmp++; n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      finish_run();
   end

   initial begin
      @(negedge clk);
      do_reset();

      // R1: reset values in every bank and both modes
      for (int b = 0; b < 4; b++)
         for (int r = 0; r < 7; r++) rd_chk(b, 0, 1, 2*r, "R1 reset register");
      rd_chk(0, 0, 1, 14, "R1 reset user sp");
      rd_chk(0, 1, 1, 14, "R1 reset system sp");

      // R2: distinct word in every banked register of every bank
      for (int b = 0; b < 4; b++)
         for (int r = 0; r < 4; r++)
            do_write(b, 0, 1, 2*r, 16'((b << 12) | (r << 8) | (b*4 + r) | 16'h0050));
      for (int b = 0; b < 4; b++)
         for (int r = 0; r < 4; r++) rd_chk(b, 0, 1, 2*r, "R2 bank isolation");

      // R3: shared registers written via one bank, read via all
      for (int r = 4; r < 7; r++) do_write(r - 3, 0, 1, 2*r, 16'(16'hC000 + r * 16'h0111));
      for (int b = 0; b < 4; b++)
         for (int r = 4; r < 7; r++) rd_chk(b, 0, 1, 2*r, "R3 shared register");

      // R5, R6: byte writes and reads across every byte index of R0..R6
      for (int b = 0; b < 4; b++)
         for (int s = 0; s < 14; s++) begin
            do_write(b, 0, 0, s, 16'(16'h5A00 | (8'hA0 + b*16 + s)));
            rd_chk(b, 0, 0, s, "R5 byte read");
            rd_chk(b, 0, 1, s & 14, "R6 other byte kept");
         end
      for (int b = 0; b < 4; b++)
         for (int s = 0; s < 16; s++) rd_chk(b, b[0], 0, s, "R5 byte sweep");

      // R7: odd index in word mode
      for (int r = 0; r < 7; r++) begin
         do_write(2, 0, 1, 2*r + 1, 16'(16'h7100 + r));
         rd_chk(2, 0, 1, 2*r, "R7 odd index write");
         rd_chk(2, 0, 1, 2*r + 1, "R7 odd index read");
      end

      // R12: read of the register written in the same cycle
      bank_sel = 2'd0; sys_mode = 1'b0;
      rd_word = 1'b1; rd_sel = 4'd8;
      wr_en = 1'b1; wr_word = 1'b1; wr_sel = 4'd8; wr_data = 16'hBEEF;
      #1;
      chk(rd_data, m_glob[0], "R12 old value during write");
      @(posedge clk); #1;
      m_glob[0] = 16'hBEEF;
      chk(rd_data, 16'hBEEF, "R12 new value after edge");
      @(negedge clk); wr_en = 1'b0;

      // R4, R13: stack alias per mode
      do_write(0, 0, 1, 14, 16'h2000);
      rd_chk(1, 1, 1, 14, "R4 system sp untouched by user write");
      do_write(3, 1, 1, 14, 16'h3000);
      rd_chk(0, 0, 1, 14, "R4 user sp kept");
      rd_chk(0, 1, 1, 14, "R4 system sp written");
      do_write(0, 1, 0, 15, 16'h0042);
      rd_chk(0, 1, 1, 14, "R4 system sp byte write");
      rd_chk(0, 0, 1, 14, "R13 user sp kept after system byte write");

      // R8, R9, R10, R13 from reset values
      do_reset();
      stack_op(0, 1, 0, "R8 first push address");
      rd_chk(0, 0, 1, 14, "R8 user sp after push");
      rd_chk(0, 1, 1, 14, "R13 system sp after user push");
      for (int k = 0; k < 8; k++) stack_op(1, 1, 0, "R8 system push sweep");
      rd_chk(0, 1, 1, 14, "R8 system sp after pushes");
      rd_chk(0, 0, 1, 14, "R13 user sp after system pushes");
      for (int k = 0; k < 5; k++) stack_op(1, 0, 1, "R9 system pop sweep");
      rd_chk(0, 1, 1, 14, "R9 system sp after pops");
      stack_op(0, 0, 1, "R9 user pop address");
      rd_chk(0, 0, 1, 14, "R9 user sp after pop");
      stack_op(0, 1, 1, "R10 push and pop address");
      rd_chk(0, 0, 1, 14, "R10 user sp unchanged");

      // R11: lone stack op beats R7 write
      wr_en = 1'b1; wr_word = 1'b1; wr_sel = 4'd14; wr_data = 16'h5555;
      stack_op(1, 1, 0, "R11 push with write address");
      wr_en = 1'b0;
      rd_chk(0, 1, 1, 14, "R11 push overrides write");
      wr_en = 1'b1; wr_sel = 4'd14; wr_data = 16'h6666;
      stack_op(0, 0, 1, "R11 pop with write address");
      wr_en = 1'b0;
      rd_chk(0, 0, 1, 14, "R11 pop overrides write");

      finish_run();
   end
endmodule